// File: doc/BRIEF.md
# UART Loop-Back Diagnostic Multiplexer

This block does the signal routing for one UART channel's internal self-test mode. When self-test is on, the external serial line and modem handshake pins are cut off. The transmit serializer's output is fed straight back into the receive deserializer. The four modem-control output bits are fed back, in a crossed pattern, as the four modem-status inputs. When self-test is off, every pin passes through unchanged.

The block also owns the modem-status byte. The upper nibble holds the current level of each status line. The lower nibble holds sticky change flags, which raise a modem interrupt request when that interrupt is enabled. In self-test mode the change flags follow the looped-back control bits and never the pins. The flags are cleared by a read strobe. The modem pins are taken to be already synchronous to `clk`. The reset input is taken to be released in step with the clock.

Top module: `uart_loopback_mux`

## Requirements
- R1: The self-test control input `lb_en_i` is captured on a rising clock edge. The routing of every path changes only after that edge, never in the same cycle that the input changes.
- R2: In self-test, `ser_rx_o` equals `ser_tx_i`, and `pin_rx_i` has no effect on it.
- R3: In self-test, `pin_tx_o` is 1 (idle mark) and `pin_mctl_n_o` is 4'b1111 (all inactive). Outside self-test, `pin_tx_o` equals `ser_tx_i` and `pin_mctl_n_o` equals `~mctl_i`.
- R4: Outside self-test, `ser_rx_o` equals `pin_rx_i`. The status nibble `msr_o[7:4]` shows the inverted active-low pins `~pin_mstat_n_i`, one cycle later.
- R5: The bit order is `mctl_i` = {aux2, aux1, rts, dtr} (bit 3 down to bit 0) and the status order is {dcd, ri, dsr, cts}. In self-test the status lines are cts = rts, dsr = dtr, ri = aux1 and dcd = aux2.
- R6: `msr_o[7:4]` holds the status registered one cycle after selection. `msr_o[3:0]` holds the sticky change flags: bit 0 marks a cts change, bit 1 a dsr change, bit 2 an ri change from active to inactive only, and bit 3 a dcd change.
- R7: In self-test, changes on `pin_mstat_n_i` alter neither the status nibble nor the change flags.
- R8: No change flag is set in the first cycle after reset. No change flag is set in the cycle that takes the first status sample after a mode switch.
- R9: A one-cycle pulse on `msr_rd_i` clears all change flags. If a new change is detected in the same cycle, its flag is set anyway.
- R10: `mdm_irq_o` is 1 exactly when `mdm_ie_i` is 1 and at least one change flag is set. This holds in both modes.
- R11: While `rst_n` is 0, `msr_o` is 0, `mdm_irq_o` is 0, and the block is outside self-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_en_i | input | 1 | Self-test enable from the modem-control register |
| mctl_i | input | 4 | Modem-control bits {aux2, aux1, rts, dtr} |
| mdm_ie_i | input | 1 | Modem-status interrupt enable |
| msr_rd_i | input | 1 | Status read strobe; clears the change flags |
| ser_tx_i | input | 1 | Serial output of the transmit serializer |
| ser_rx_o | output | 1 | Serial input to the receive deserializer |
| pin_rx_i | input | 1 | External serial receive pin |
| pin_tx_o | output | 1 | External serial transmit pin |
| pin_mstat_n_i | input | 4 | External active-low status pins {dcd, ri, dsr, cts} |
| pin_mctl_n_o | output | 4 | External active-low control pins {aux2, aux1, rts, dtr} |
| msr_o | output | 8 | Status levels [7:4] and change flags [3:0] |
| mdm_irq_o | output | 1 | Modem-status interrupt request |

## Verification
A status read can fall in the same cycle as a fresh status change. The clear must not swallow the new flag, while the older flags must still be cleared. The bench provokes this by pulsing `msr_rd_i` in the same cycle that it drops the cts pin. It then expects only the cts flag in `msr_o[3:0]`. A mode switch can also coincide with a status difference between the two sources. The bench judges this by checking that no flag appears across entry into and exit from self-test.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int MDM_W = 4;
  localparam int MSR_W = 2 * MDM_W;

  // status line positions (msr nibble order)
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_DCD = 3;

  // control bit positions (decoded by the register block)
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_AUX1 = 2;
  localparam int MC_AUX2 = 3;

  typedef logic [MDM_W-1:0] mdm_t;

  // crossed feedback of control bits onto status lines in self-test
  function automatic mdm_t lb_map(input mdm_t ctl);
    mdm_t res;
    res[ST_CTS] = ctl[MC_RTS];
    res[ST_DSR] = ctl[MC_DTR];
    res[ST_RI]  = ctl[MC_AUX1];
    res[ST_DCD] = ctl[MC_AUX2];
    return res;
  endfunction
endpackage

// File: rtl/uart_lb_mode.sv
module uart_lb_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_en_i,
  output logic lb_q_o
);
  logic lb_d;
  logic lb_q;

  always_comb begin
    lb_d = lb_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lb_q <= 1'b0;
    else        lb_q <= lb_d;
  end

  assign lb_q_o = lb_q;
endmodule

// File: rtl/uart_lb_route.sv
module uart_lb_route
  import uart_lb_pkg::*;
#(
  parameter int CTL_W = MDM_W
) (
  input  logic             lb_i,
  input  logic [CTL_W-1:0] mctl_i,
  input  logic             ser_tx_i,
  output logic             ser_rx_o,
  input  logic             pin_rx_i,
  output logic             pin_tx_o,
  output logic [CTL_W-1:0] pin_mctl_n_o
);
  localparam logic IDLE_MARK = 1'b1;
  localparam logic CTL_OFF_N = 1'b1;

  always_comb begin
    ser_rx_o = lb_i ? ser_tx_i : pin_rx_i;
    pin_tx_o = lb_i ? IDLE_MARK : ser_tx_i;
  end

  for (genvar g = 0; g < CTL_W; g++) begin : g_ctl
    assign pin_mctl_n_o[g] = lb_i ? CTL_OFF_N : ~mctl_i[g];
  end
endmodule

// File: rtl/uart_lb_mstat.sv
module uart_lb_mstat
  import uart_lb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lb_i,
  input  mdm_t       mctl_i,
  input  mdm_t       pin_mstat_n_i,
  input  logic       rd_i,
  output mdm_t       stat_o,
  output mdm_t       delta_o
);
  mdm_t stat_sel, stat_q, chg, evt, set_w, delta_d, delta_q;
  logic src_q, prime_q, arm, delta_en;

  always_comb begin
    stat_sel = lb_i ? lb_map(mctl_i) : ~pin_mstat_n_i;
    chg      = stat_sel ^ stat_q;
    evt         = chg;
    evt[ST_RI]  = stat_q[ST_RI] & ~stat_sel[ST_RI];
    arm      = prime_q && (src_q == lb_i);
    set_w    = arm ? evt : '0;
    delta_en = rd_i || (set_w != '0);
    delta_d  = (rd_i ? '0 : delta_q) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      src_q   <= 1'b0;
      prime_q <= 1'b0;
    end else begin
      stat_q  <= stat_sel;
      src_q   <= lb_i;
      prime_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        delta_q <= '0;
    else if (delta_en) delta_q <= delta_d;
  end

  assign stat_o  = stat_q;
  assign delta_o = delta_q;

  // R8: no flag appears after reset or across a source switch
  assert_no_switch_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prime_q || (src_q != lb_i)) |=> ((delta_q & ~$past(delta_q)) == '0));

  // R9: a read with no new change leaves all flags clear
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (set_w == '0)) |=> (delta_q == '0));
endmodule

// File: rtl/uart_loopback_mux.sv
module uart_loopback_mux
  import uart_lb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_en_i,
  input  logic [MDM_W-1:0] mctl_i,
  input  logic             mdm_ie_i,
  input  logic             msr_rd_i,
  input  logic             ser_tx_i,
  output logic             ser_rx_o,
  input  logic             pin_rx_i,
  output logic             pin_tx_o,
  input  logic [MDM_W-1:0] pin_mstat_n_i,
  output logic [MDM_W-1:0] pin_mctl_n_o,
  output logic [MSR_W-1:0] msr_o,
  output logic             mdm_irq_o
);
  logic lb_q;
  mdm_t stat, delta;

  uart_lb_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .lb_en_i(lb_en_i),
    .lb_q_o (lb_q)
  );

  uart_lb_route #(.CTL_W(MDM_W)) u_route (
    .lb_i        (lb_q),
    .mctl_i      (mctl_i),
    .ser_tx_i    (ser_tx_i),
    .ser_rx_o    (ser_rx_o),
    .pin_rx_i    (pin_rx_i),
    .pin_tx_o    (pin_tx_o),
    .pin_mctl_n_o(pin_mctl_n_o)
  );

  uart_lb_mstat u_mstat (
    .clk          (clk),
    .rst_n        (rst_n),
    .lb_i         (lb_q),
    .mctl_i       (mctl_i),
    .pin_mstat_n_i(pin_mstat_n_i),
    .rd_i         (msr_rd_i),
    .stat_o       (stat),
    .delta_o      (delta)
  );

  always_comb begin
    msr_o     = {stat, delta};
    mdm_irq_o = mdm_ie_i && (delta != '0);
  end

  // R2: in self-test the receiver sees the transmitter
  assert_tx_to_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lb_en_i)) |-> (ser_rx_o == ser_tx_i));

  // R3: pins idle while self-test is active
  assert_pins_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lb_en_i)) |-> (pin_tx_o && (pin_mctl_n_o == '1)));

  // R4: outside self-test the receive pin passes through
  assert_rx_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lb_en_i)) |-> (ser_rx_o == pin_rx_i));

  // R5: crossed mapping seen in the status nibble
  assert_cross_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(lb_en_i, 2)) |->
    (msr_o[MSR_W-1:MDM_W] == {$past(mctl_i[MC_AUX2]), $past(mctl_i[MC_AUX1]),
                              $past(mctl_i[MC_DTR]), $past(mctl_i[MC_RTS])}));
endmodule

// File: tb/uart_loopback_mux_test.sv
`timescale 1ns/1ps
module uart_loopback_mux_test;
  logic clk = 1'b0;
  logic rst_n;
  logic lb_en, ie, rd, stx, prx;
  logic [3:0] mctl, pinn;
  logic srx, ptx, irq;
  logic [3:0] pmn;
  logic [7:0] msr;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  uart_loopback_mux uut (
    .clk(clk), .rst_n(rst_n), .lb_en_i(lb_en), .mctl_i(mctl), .mdm_ie_i(ie),
    .msr_rd_i(rd), .ser_tx_i(stx), .ser_rx_o(srx), .pin_rx_i(prx),
    .pin_tx_o(ptx), .pin_mstat_n_i(pinn), .pin_mctl_n_o(pmn), .msr_o(msr),
    .mdm_irq_o(irq)
  );

  // stimulus {lb, mctl[3:0], ser_tx, pin_rx, pin_n[3:0]}
  localparam logic [10:0] STIM [8] = '{
    11'b0_0000_1_0_1111, 11'b0_1010_0_1_0101, 11'b0_0101_1_1_1010,
    11'b1_0001_0_1_0000, 11'b1_0010_1_0_1111, 11'b1_0100_0_0_1010,
    11'b1_1000_1_1_0000, 11'b0_0011_0_0_1110};
  // expected {ser_rx, pin_tx, pin_mctl_n[3:0], status[3:0]}
  localparam logic [9:0] EXPV [8] = '{
    10'b0_1_1111_0000, 10'b1_0_0101_1010, 10'b1_1_1010_0101,
    10'b0_1_1111_0010, 10'b1_1_1111_0001, 10'b0_1_1111_0100,
    10'b1_1_1111_1000, 10'b0_0_1100_0001};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lb_en = 1'b0; ie = 1'b1; rd = 1'b0; stx = 1'b0; prx = 1'b1;
    mctl = 4'b0000; pinn = 4'b1110;
    step(); step();
    // R11 reset state
    chk("R11 msr in reset", msr, 8'h00);
    chk("R11 irq in reset", irq, 1'b0);
    chk("R11 not in self-test", ptx, stx);
    rst_n = 1'b1;
    step();
    chk("R8 no flag after reset", msr, 8'h10);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      {lb_en, mctl, stx, prx, pinn} = STIM[i];
      step(); step();
      chk("R2/R4 ser_rx", srx, EXPV[i][9]);
      chk("R3 pin_tx", ptx, EXPV[i][8]);
      chk("R3 pin_mctl_n", pmn, EXPV[i][7:4]);
      chk("R5/R4 status", msr[7:4], EXPV[i][3:0]);
    end

    // clear flags, normal mode, pins 1100 -> status 0011
    pinn = 4'b1100; rd = 1'b1; step(); rd = 1'b0; step();
    rd = 1'b1; step(); rd = 1'b0;
    chk("R9 read clears", msr, 8'h30);
    // R6 ri rising sets nothing
    pinn = 4'b1000; step();
    chk("R6 ri rising no flag", msr, 8'h70);
    pinn = 4'b1100; step();
    chk("R6 ri falling flag", msr, 8'h34);
    chk("R10 irq enabled", irq, 1'b1);
    ie = 1'b0; #1;
    chk("R10 irq masked", irq, 1'b0);
    ie = 1'b1;
    // R9 read together with a new cts change
    pinn = 4'b1101; rd = 1'b1; step(); rd = 1'b0;
    chk("R9 set wins over clear", msr, 8'h21);
    step();
    chk("R9 flag held", msr, 8'h21);
    rd = 1'b1; step(); rd = 1'b0;
    chk("R9 cleared", msr, 8'h20);

    // R1 switch only on clock edge
    stx = 1'b0; prx = 1'b1; mctl = 4'b0000;
    lb_en = 1'b1; #2;
    chk("R1 rx unchanged before edge", srx, 1'b1);
    chk("R1 tx unchanged before edge", ptx, 1'b0);
    step();
    chk("R1 rx after edge", srx, 1'b0);
    chk("R1 tx after edge", ptx, 1'b1);
    step();
    chk("R8 no flag entering self-test", msr, 8'h00);
    // R7 pins ignored in self-test
    pinn = 4'b0000; step(); step();
    chk("R7 pins ignored", msr, 8'h00);
    mctl = 4'b0010; step();
    chk("R5 rts to cts flag", msr, 8'h11);
    chk("R10 irq in self-test", irq, 1'b1);
    rd = 1'b1; step(); rd = 1'b0;
    mctl = 4'b0110; step();
    chk("R6 ri rising in self-test", msr, 8'h50);
    mctl = 4'b0010; step();
    chk("R6 ri falling in self-test", msr, 8'h14);
    rd = 1'b1; step(); rd = 1'b0;
    // leave self-test
    pinn = 4'b1111; lb_en = 1'b0; step(); step();
    chk("R8 no flag leaving self-test", msr, 8'h00);
    chk("R4 rx pass after leaving", srx, prx);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule